// File: doc/BRIEF.md
# Dual-CPU shared RAM arbiter

This block joins the buses of two 8-bit processors, one primary and one secondary, through a 2 KiB shared work RAM and a pair of cross-processor interrupt lines. Each side brings its own address, write data, read/not-write flag and bus-cycle strobe, and gets back its own read data and an active-low interrupt. Both sides share one clock and one reset.

Each side has a one-bit control latch at address $4016. The primary's latch decides which side may use the shared RAM. Each side's latch also drives the interrupt line into the other processor as a held level, not as a pulse. Reading $4016 tells a processor whether it is the primary or the secondary. The side that does not own the RAM sees open bus in the $6000–$7FFF window. Open bus is modelled as the last data value seen on that side's bus.

Top module: `xcs_share_arb`

## Requirements
- R1: The shared RAM holds 2048 bytes and is mirrored across $6000–$7FFF. Only address bits 10:0 select the byte, so all four mirrors of an offset reach the same byte.
- R2: A write by the secondary to $4016 never changes RAM ownership. Only primary writes to $4016 do.
- R3: When the primary last wrote bit 1 (mask 0x02) of $4016 as 1, the primary owns the RAM. When it last wrote that bit as 0, the secondary owns it. When both sides access the window in the same cycle, only the owner reaches the RAM.
- R4: A read by the side that does not own the RAM returns that side's held bus value and does not return RAM data. The held value is the data of that side's last bus cycle: the written byte, or the byte returned by a read. Reads of addresses outside the window and outside $4016 also return the held value. Writes by the non-owner do not change any RAM byte.
- R5: Each side's last written bit 1 of $4016 drives the other side's interrupt output. A 0 drives it low (asserted) and a 1 drives it high (released).
- R6: An asserted interrupt stays low across idle cycles and across unrelated accesses, until the writing side writes bit 1 back to 1.
- R7: A read of $4016 returns 0x00 on the primary side and 0x80 on the secondary side. Bit 7 is the role bit and every other bit reads 0, whatever was written before.
- R8: After reset, both control bits are 1. The primary therefore owns the RAM, both interrupt outputs are high, and both read-data outputs are 0x00.
- R9: Ownership and the two interrupt levels are independent. The primary's interrupt stays as the secondary last set it when ownership moves in either direction.
- R10: A write takes effect at the clock edge that samples its strobe high. Read data appears on the read-data output after that same edge and holds until the side's next bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock for both sides |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pri_addr_i | input | 16 | Primary address |
| pri_wdata_i | input | 8 | Primary write data |
| pri_rnw_i | input | 1 | Primary direction: 1 read, 0 write |
| pri_strobe_i | input | 1 | Primary bus cycle valid this clock |
| pri_rdata_o | output | 8 | Primary read data (registered) |
| pri_irq_no | output | 1 | Interrupt into the primary, active low |
| sec_addr_i | input | 16 | Secondary address |
| sec_wdata_i | input | 8 | Secondary write data |
| sec_rnw_i | input | 1 | Secondary direction: 1 read, 0 write |
| sec_strobe_i | input | 1 | Secondary bus cycle valid this clock |
| sec_rdata_o | output | 8 | Secondary read data (registered) |
| sec_irq_no | output | 1 | Interrupt into the secondary, active low |

## Verification
The assertions check on every cycle the following:
- each control write moves the opposite interrupt line to the written level;
- an asserted line stays low until it is rewritten;
- ownership changes only on primary control writes;
- role reads return the fixed words;
- a non-owner read leaves its read data unchanged.

Only the bench scenarios can show the rest:
- that the RAM is mirrored across all four mirrors;
- that writes by the non-owner are really lost, by handing ownership back and reading the bytes;
- that same-cycle writes from both sides resolve in favour of the owner;
- that the interrupt levels stay unchanged through ownership transfers.

// File: rtl/xcs_pkg.sv
package xcs_pkg;

  typedef struct packed {
    logic win;
    logic ctl;
    logic rd;
    logic wr;
  } bus_dec_t;

endpackage

// File: rtl/xcs_decode.sv
module xcs_decode
  import xcs_pkg::*;
#(
  parameter int          AW       = 16,
  parameter logic [15:0] WIN_BASE = 16'h6000,
  parameter logic [15:0] WIN_MASK = 16'hE000,
  parameter logic [15:0] CTL_ADDR = 16'h4016
) (
  input  logic [AW-1:0] addr_i,
  input  logic          strobe_i,
  input  logic          rnw_i,
  output bus_dec_t      dec_o
);

  localparam logic [AW-1:0] BASE = AW'(WIN_BASE);
  localparam logic [AW-1:0] MASK = AW'(WIN_MASK);
  localparam logic [AW-1:0] CTL  = AW'(CTL_ADDR);

  always_comb begin
    dec_o.win = ((addr_i & MASK) == BASE);
    dec_o.ctl = (addr_i == CTL);
    dec_o.rd  = strobe_i & rnw_i;
    dec_o.wr  = strobe_i & ~rnw_i;
  end

endmodule

// File: rtl/xcs_side.sv
module xcs_side
  import xcs_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CTL_BIT  = 1,
  parameter int ROLE_BIT = 7,
  parameter bit IS_SEC   = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_dec_t      dec_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          own_i,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          ctl_bit_o,
  output logic [DW-1:0] rdata_o
);

  localparam logic [DW-1:0] ROLE_WORD = IS_SEC ? (DW'(1) << ROLE_BIT) : '0;

  logic          ctl_q;
  logic [DW-1:0] bus_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= 1'b1;
    end else if (dec_i.wr && dec_i.ctl) begin
      ctl_q <= wdata_i[CTL_BIT];
    end
  end

  // bus_q doubles as open-bus latch: holds last data seen on this side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q <= '0;
    end else if (dec_i.wr) begin
      bus_q <= wdata_i;
    end else if (dec_i.rd) begin
      if (dec_i.ctl)              bus_q <= ROLE_WORD;
      else if (dec_i.win && own_i) bus_q <= ram_rdata_i;
    end
  end

  assign ctl_bit_o = ctl_q;
  assign rdata_o   = bus_q;

endmodule

// File: rtl/xcs_ram.sv
module xcs_ram #(
  parameter int DW    = 8,
  parameter int RAM_AW = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [RAM_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);

  localparam int DEPTH = 1 << RAM_AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/xcs_share_arb.sv
module xcs_share_arb
  import xcs_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter int          RAM_AW   = 11,
  parameter int          CTL_BIT  = 1,
  parameter int          ROLE_BIT = 7,
  parameter logic [15:0] WIN_BASE = 16'h6000,
  parameter logic [15:0] WIN_MASK = 16'hE000,
  parameter logic [15:0] CTL_ADDR = 16'h4016
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] pri_addr_i,
  input  logic [DW-1:0] pri_wdata_i,
  input  logic          pri_rnw_i,
  input  logic          pri_strobe_i,
  output logic [DW-1:0] pri_rdata_o,
  output logic          pri_irq_no,
  input  logic [AW-1:0] sec_addr_i,
  input  logic [DW-1:0] sec_wdata_i,
  input  logic          sec_rnw_i,
  input  logic          sec_strobe_i,
  output logic [DW-1:0] sec_rdata_o,
  output logic          sec_irq_no
);

  localparam int NSIDE = 2;

  logic [NSIDE-1:0][AW-1:0] addr_s;
  logic [NSIDE-1:0][DW-1:0] wdata_s;
  logic [NSIDE-1:0][DW-1:0] rdata_s;
  logic [NSIDE-1:0]         rnw_s, strobe_s, ctl_s, own_s;
  bus_dec_t [NSIDE-1:0]     dec_s;

  logic              own_sec;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [DW-1:0]     ram_wdata, ram_rdata;

  assign addr_s   = {sec_addr_i, pri_addr_i};
  assign wdata_s  = {sec_wdata_i, pri_wdata_i};
  assign rnw_s    = {sec_rnw_i, pri_rnw_i};
  assign strobe_s = {sec_strobe_i, pri_strobe_i};

  // side 0 primary, side 1 secondary
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    xcs_decode #(
      .AW(AW), .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK), .CTL_ADDR(CTL_ADDR)
    ) u_dec (
      .addr_i   (addr_s[s]),
      .strobe_i (strobe_s[s]),
      .rnw_i    (rnw_s[s]),
      .dec_o    (dec_s[s])
    );

    xcs_side #(
      .DW(DW), .CTL_BIT(CTL_BIT), .ROLE_BIT(ROLE_BIT), .IS_SEC(s == 1)
    ) u_side (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .dec_i       (dec_s[s]),
      .wdata_i     (wdata_s[s]),
      .own_i       (own_s[s]),
      .ram_rdata_i (ram_rdata),
      .ctl_bit_o   (ctl_s[s]),
      .rdata_o     (rdata_s[s])
    );
  end

  // only the primary latch picks the owner
  assign own_sec  = ~ctl_s[0];
  assign own_s    = {own_sec, ~own_sec};

  assign ram_addr  = own_sec ? addr_s[1][RAM_AW-1:0] : addr_s[0][RAM_AW-1:0];
  assign ram_wdata = own_sec ? wdata_s[1] : wdata_s[0];
  assign ram_we    = own_sec ? (dec_s[1].wr & dec_s[1].win)
                             : (dec_s[0].wr & dec_s[0].win);

  xcs_ram #(.DW(DW), .RAM_AW(RAM_AW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .addr_i  (ram_addr),
    .wdata_i (ram_wdata),
    .rdata_o (ram_rdata)
  );

  assign pri_rdata_o = rdata_s[0];
  assign sec_rdata_o = rdata_s[1];
  // cross wiring: each latch interrupts the opposite side
  assign sec_irq_no  = ctl_s[0];
  assign pri_irq_no  = ctl_s[1];

endmodule

// File: rtl/xcs_share_arb_chk.sv
module xcs_share_arb_chk #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter int          CTL_BIT  = 1,
  parameter int          ROLE_BIT = 7,
  parameter logic [15:0] WIN_BASE = 16'h6000,
  parameter logic [15:0] WIN_MASK = 16'hE000,
  parameter logic [15:0] CTL_ADDR = 16'h4016
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] pri_addr_i,
  input logic [DW-1:0] pri_wdata_i,
  input logic          pri_rnw_i,
  input logic          pri_strobe_i,
  input logic [DW-1:0] pri_rdata_o,
  input logic          pri_irq_no,
  input logic [AW-1:0] sec_addr_i,
  input logic [DW-1:0] sec_wdata_i,
  input logic          sec_rnw_i,
  input logic          sec_strobe_i,
  input logic [DW-1:0] sec_rdata_o,
  input logic          sec_irq_no,
  input logic          own_sec
);

  localparam logic [DW-1:0] SEC_WORD = DW'(1) << ROLE_BIT;

  logic p_ctl_wr, s_ctl_wr, p_ctl_rd, s_ctl_rd, p_win_rd, s_win_rd;

  assign p_ctl_wr = pri_strobe_i && !pri_rnw_i && (pri_addr_i == AW'(CTL_ADDR));
  assign s_ctl_wr = sec_strobe_i && !sec_rnw_i && (sec_addr_i == AW'(CTL_ADDR));
  assign p_ctl_rd = pri_strobe_i && pri_rnw_i && (pri_addr_i == AW'(CTL_ADDR));
  assign s_ctl_rd = sec_strobe_i && sec_rnw_i && (sec_addr_i == AW'(CTL_ADDR));
  assign p_win_rd = pri_strobe_i && pri_rnw_i && ((pri_addr_i & AW'(WIN_MASK)) == AW'(WIN_BASE));
  assign s_win_rd = sec_strobe_i && sec_rnw_i && ((sec_addr_i & AW'(WIN_MASK)) == AW'(WIN_BASE));

  AST_PRI_CTL_DRIVES_SEC_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_ctl_wr |=> (sec_irq_no == $past(pri_wdata_i[CTL_BIT])));  // R5
  AST_SEC_CTL_DRIVES_PRI_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ctl_wr |=> (pri_irq_no == $past(sec_wdata_i[CTL_BIT])));  // R5
  AST_SEC_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_irq_no && !p_ctl_wr) |=> !sec_irq_no);  // R6
  AST_PRI_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pri_irq_no && !s_ctl_wr) |=> !pri_irq_no);  // R6
  AST_OWN_ONLY_BY_PRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_ctl_wr |=> $stable(own_sec));  // R2
  AST_OWN_FOLLOWS_PRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_ctl_wr |=> (own_sec == !$past(pri_wdata_i[CTL_BIT])));  // R3
  AST_ROLE_PRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_ctl_rd |=> (pri_rdata_o == '0));  // R7
  AST_ROLE_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ctl_rd |=> (sec_rdata_o == SEC_WORD));  // R7
  AST_PRI_NONOWN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_win_rd && own_sec) |=> $stable(pri_rdata_o));  // R4
  AST_SEC_NONOWN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_win_rd && !own_sec) |=> $stable(sec_rdata_o));  // R4

endmodule

bind xcs_share_arb xcs_share_arb_chk #(
  .AW(AW), .DW(DW), .CTL_BIT(CTL_BIT), .ROLE_BIT(ROLE_BIT),
  .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK), .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pri_addr_i   (pri_addr_i),
  .pri_wdata_i  (pri_wdata_i),
  .pri_rnw_i    (pri_rnw_i),
  .pri_strobe_i (pri_strobe_i),
  .pri_rdata_o  (pri_rdata_o),
  .pri_irq_no   (pri_irq_no),
  .sec_addr_i   (sec_addr_i),
  .sec_wdata_i  (sec_wdata_i),
  .sec_rnw_i    (sec_rnw_i),
  .sec_strobe_i (sec_strobe_i),
  .sec_rdata_o  (sec_rdata_o),
  .sec_irq_no   (sec_irq_no),
  .own_sec      (own_sec)
);

// File: tb/xcs_share_arb_bench.sv
module xcs_share_arb_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CTL = 16'h4016;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] p_addr = '0, s_addr = '0;
  logic [7:0]  p_wd = '0, s_wd = '0;
  logic        p_rnw = 1'b1, s_rnw = 1'b1, p_stb = 1'b0, s_stb = 1'b0;
  logic [7:0]  p_rd, s_rd;
  logic        p_irq_n, s_irq_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model
  logic [7:0] mm [2048];
  logic [7:0] p_last = '0, s_last = '0;
  logic       pctl = 1'b1, sctl = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcs_share_arb u_xcs_share_arb (
    .clk_i(clk), .rst_ni(rst_n),
    .pri_addr_i(p_addr), .pri_wdata_i(p_wd), .pri_rnw_i(p_rnw), .pri_strobe_i(p_stb),
    .pri_rdata_o(p_rd), .pri_irq_no(p_irq_n),
    .sec_addr_i(s_addr), .sec_wdata_i(s_wd), .sec_rnw_i(s_rnw), .sec_strobe_i(s_stb),
    .sec_rdata_o(s_rd), .sec_irq_no(s_irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [15:0] a);
    return a[15:13] == 3'b011;
  endfunction

  // one clock: drive at negedge, sample at the following negedge
  task automatic cyc(input string tag,
                     input bit pv, input logic [15:0] pa, input bit prd, input logic [7:0] pd,
                     input bit sv, input logic [15:0] sa, input bit srd, input logic [7:0] sd);
    logic       np, ns;
    logic [7:0] mp, ms;
    np = pctl; ns = sctl;
    mp = mm[pa[10:0]]; ms = mm[sa[10:0]];
    p_stb = pv; p_addr = pa; p_rnw = prd; p_wd = pd;
    s_stb = sv; s_addr = sa; s_rnw = srd; s_wd = sd;
    if (pv) begin
      if (!prd) begin
        p_last = pd;
        if (pa == CTL) np = pd[1];
        if (in_win(pa) && pctl) mm[pa[10:0]] = pd;
      end else if (pa == CTL) p_last = 8'h00;
      else if (in_win(pa) && pctl) p_last = mp;
    end
    if (sv) begin
      if (!srd) begin
        s_last = sd;
        if (sa == CTL) ns = sd[1];
        if (in_win(sa) && !pctl) mm[sa[10:0]] = sd;
      end else if (sa == CTL) s_last = 8'h80;
      else if (in_win(sa) && !pctl) s_last = ms;
    end
    pctl = np; sctl = ns;
    @(posedge clk);
    @(negedge clk);
    p_stb = 1'b0; s_stb = 1'b0;
    if (pv) chk({tag, " pri_rdata"}, p_rd, p_last);
    if (sv) chk({tag, " sec_rdata"}, s_rd, s_last);
  endtask

  task automatic pw(input string t, input logic [15:0] a, input logic [7:0] d);
    cyc(t, 1, a, 0, d, 0, 16'h0, 1, 8'h0);
  endtask
  task automatic pr(input string t, input logic [15:0] a);
    cyc(t, 1, a, 1, 8'h0, 0, 16'h0, 1, 8'h0);
  endtask
  task automatic sw(input string t, input logic [15:0] a, input logic [7:0] d);
    cyc(t, 0, 16'h0, 1, 8'h0, 1, a, 0, d);
  endtask
  task automatic sr(input string t, input logic [15:0] a);
    cyc(t, 0, 16'h0, 1, 8'h0, 1, a, 1, 8'h0);
  endtask
  task automatic irqs(input string t);
    chk({t, " pri_irq_n"}, {7'b0, p_irq_n}, {7'b0, sctl});
    chk({t, " sec_irq_n"}, {7'b0, s_irq_n}, {7'b0, pctl});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 pri_rdata", p_rd, 8'h00);
    chk("R8 sec_rdata", s_rd, 8'h00);
    chk("R8 pri_irq_n", {7'b0, p_irq_n}, 8'h01);
    chk("R8 sec_irq_n", {7'b0, s_irq_n}, 8'h01);

    // R1/R10 mirror sweep by the owning primary
    for (int i = 0; i < 64; i++) begin
      logic [10:0] off;
      off = 11'((i * 33) % 2048);
      pw("R1 wr", 16'h6000 + {5'b0, off} + 16'((i % 4) * 16'h800), 8'((i * 7 + 3) & 8'hff));
      pr("R1 R10 mirror", 16'h6000 + {5'b0, off} + 16'(((i + 1) % 4) * 16'h800));
    end
    // R4 secondary is non-owner: reads hold its bus value
    sw("R4 prime", 16'h0123, 8'h3C);
    sr("R4 nonowner read sec", 16'h6000);
    sr("R4 other addr", 16'h0200);

    // R7 role reads
    pw("R7 pri ctl keep", CTL, 8'hFF);
    pr("R7 role pri", CTL);
    sw("R7 sec ctl", CTL, 8'hFF);
    sr("R7 role sec", CTL);
    irqs("R5 both high");

    // R2 secondary ctl write leaves ownership
    sw("R2 sec ctl0", CTL, 8'h00);
    irqs("R5 pri irq asserted");
    pr("R2 pri still owns", 16'h6021);
    sr("R2 sec still open bus", 16'h7021);
    sw("R5 sec release", CTL, 8'h02);
    irqs("R5 pri irq released");

    // R3 handover to secondary
    pw("R3 pri ctl0", CTL, 8'hFD);
    irqs("R5 sec irq asserted");
    sr("R3 sec sees shared data", 16'h6021);
    pr("R4 pri open bus", 16'h6021);
    pw("R4 pri write ignored", 16'h6042, 8'h5A);
    sw("R3 sec write", 16'h6100, 8'hC3);
    repeat (40) @(negedge clk);
    irqs("R6 held idle");
    sw("R6 sec unrelated", 16'h0300, 8'h11);
    pr("R6 pri unrelated", 16'h0400);
    irqs("R6 held access");

    // R9 independence
    sw("R9 sec ctl0", CTL, 8'h00);
    pw("R9 pri takes back", CTL, 8'h02);
    irqs("R9 pri irq stays");
    pr("R3 pri sees sec data", 16'h7100);
    pr("R4 lost write", 16'h6042);
    pw("R9 pri gives", CTL, 8'h00);
    irqs("R9 after give");
    sw("R9 sec release", CTL, 8'h02);
    irqs("R9 after release");

    // R3 simultaneous writes over all control combos
    for (int c = 0; c < 4; c++) begin
      cyc("R5 R3 ctl both", 1, CTL, 0, {6'b0, c[1], 1'b0}, 1, CTL, 0, {6'b0, c[0], 1'b0});
      irqs("R5 combo");
      cyc("R3 dual write", 1, 16'h6555, 0, 8'(8'hA0 + c), 1, 16'h7555, 0, 8'(8'h50 + c));
      cyc("R3 dual read", 1, 16'h6555, 1, 8'h0, 1, 16'h6D55, 1, 8'h0);
    end
    pw("R8 restore", CTL, 8'h02);
    sw("R8 restore sec", CTL, 8'h02);
    irqs("R5 final");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule